// File: doc/BRIEF.md
# Big-Endian Load/Store Lane Aligner

This block sits between the memory stage of a 32-bit datapath and a byte-addressed data memory that is one word wide. For a store, it takes the access type, an effective byte address that has already been computed, and the store data. It turns these into a word address, per-byte write enables and a write word with the payload copied into the correct lanes. For a load, it records the type and the low address bits when the request is accepted. When the memory returns the word, it picks out the addressed byte or halfword and sign-extends or zero-extends it to 32 bits.

Lanes are mapped big-endian: byte offset 0 is bits 31:24 and offset 3 is bits 7:0. A halfword access with an odd address is misaligned. A word access whose address is not a multiple of four is also misaligned. The block flags such a request, consumes it in one cycle and never passes it to the memory.

Every data path uses valid/ready. A request is accepted when `req_valid` and `req_ready` are both high. While a load is outstanding, `req_ready` is low, so only one load is in flight at a time. A well-formed request also needs `mem_req_ready` before it is accepted. The memory response is forwarded without change: `ld_valid` follows `mem_rvalid` while a load is pending, and `mem_rready` follows `ld_ready`. If the consumer stalls, the memory must hold its response word. The load result is combinational from that word.

Top module: `lsa_top`

## Requirements
- R1: An issued memory request carries the word address `req_addr >> 2` on `mem_waddr`. The access code is: 0 load word, 1 load half signed, 2 load half unsigned, 3 load byte signed, 4 load byte unsigned, 5 store word, 6 store half, 7 store byte. Codes 5 to 7 are stores and drive `mem_we` high; codes 0 to 4 drive `mem_we` low and `mem_be` to 0.
- R2: A byte store copies `req_wdata[7:0]` into all four lanes. It asserts only `mem_be[3-off]`, where off is `req_addr[1:0]` and `mem_be[3]` drives bits 31:24.
- R3: A halfword store copies `req_wdata[15:0]` into both halves. It asserts `mem_be` 4'b1100 when `req_addr[1]` is 0 and 4'b0011 when it is 1.
- R4: A word store passes `req_wdata` unchanged and asserts `mem_be` 4'b1111.
- R5: A halfword access with `req_addr[0]`=1, or a word access with `req_addr[1:0]`≠0, raises `req_misalign`. While that request is presented, `mem_req_valid` stays low and `mem_be` is 0. The request is accepted in the same cycle without waiting for `mem_req_ready`.
- R6: A signed byte load returns the byte at big-endian offset off (bits 31-8·off down to 24-8·off of `mem_rdata`), with its bit 7 copied into bits 31:8.
- R7: An unsigned byte load returns the same byte with bits 31:8 cleared.
- R8: A signed halfword load returns `mem_rdata[31:16]` when addr[1]=0 and `mem_rdata[15:0]` when addr[1]=1, with that halfword's bit 15 copied into bits 31:16.
- R9: An unsigned halfword load returns the same halfword with bits 31:16 cleared.
- R10: A word load returns `mem_rdata` unchanged.
- R11: After a load is accepted, `req_ready` stays low until its result is taken. The result is formed from the type and address captured at acceptance, not from the current request inputs.
- R12: `ld_valid` equals `mem_rvalid` while a load is pending, and `mem_rready` equals `ld_ready`. A stalled result stays valid and unchanged while the memory holds its word.
- R13: After reset no load is pending: `ld_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_acc | input | 3 | Access type code |
| req_addr | input | ADDR_W | Effective byte address |
| req_wdata | input | 32 | Store payload, right-justified |
| req_misalign | output | 1 | Presented request is misaligned |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory can take a request |
| mem_we | output | 1 | Memory request is a write |
| mem_waddr | output | ADDR_W-2 | Memory word address |
| mem_be | output | 4 | Byte write enables, bit 3 is lane 31:24 |
| mem_wdata | output | 32 | Lane-placed write word |
| mem_rvalid | input | 1 | Read word valid |
| mem_rready | output | 1 | Read word consumed |
| mem_rdata | input | 32 | Read word from memory |
| ld_valid | output | 1 | Load result valid |
| ld_ready | input | 1 | Consumer takes load result |
| ld_data | output | 32 | Extended load result |

## Verification
The bench covers every access type at all four offsets. Swapping lanes to little-endian would put the wrong byte into the result and the enable on the mirrored lane. Extending with the wrong bit would corrupt the upper bits of loaded values whose top bit is set. Misaligned halfword and word requests are sent on purpose: a design that forwarded them would show `mem_req_valid` or a nonzero enable. After a load is accepted, the bench scrambles the request inputs and stalls the consumer at random. A design that decoded the live address, or that let a new request in early, would return wrong data or drop back-pressure.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int OFF_W  = $clog2(LANES);

  typedef enum logic [2:0] {
    ACC_LW  = 3'd0,
    ACC_LH  = 3'd1,
    ACC_LHU = 3'd2,
    ACC_LB  = 3'd3,
    ACC_LBU = 3'd4,
    ACC_SW  = 3'd5,
    ACC_SH  = 3'd6,
    ACC_SB  = 3'd7
  } acc_e;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2} size_e;

  function automatic size_e size_of(input acc_e a);
    case (a)
      ACC_LW, ACC_SW:          return SZ_W;
      ACC_LH, ACC_LHU, ACC_SH: return SZ_H;
      default:                 return SZ_B;
    endcase
  endfunction

  function automatic logic is_store(input acc_e a);
    return (a == ACC_SW) || (a == ACC_SH) || (a == ACC_SB);
  endfunction
endpackage

// File: rtl/lsa_align_chk.sv
module lsa_align_chk
  import lsa_pkg::*;
(
  input  acc_e             acc,
  input  logic [OFF_W-1:0] off,
  output logic             misalign
);
  always_comb begin
    case (size_of(acc))
      SZ_H:    misalign = off[0];
      SZ_W:    misalign = (off != '0);
      default: misalign = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsa_store_fmt.sv
module lsa_store_fmt
  import lsa_pkg::*;
(
  input  acc_e              acc,
  input  logic [OFF_W-1:0]  off,
  input  logic              misalign,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  be,
  output logic [DATA_W-1:0] lane_data
);
  logic  store_ok;
  size_e sz;

  assign sz       = size_of(acc);
  assign store_ok = is_store(acc) && !misalign;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int BIG_OFF = LANES - 1 - i;
    localparam bit UPPER   = (i >= LANES / 2);
    always_comb begin
      case (sz)
        SZ_B: begin
          lane_data[8*i +: 8] = wdata[7:0];
          be[i] = store_ok && (off == OFF_W'(BIG_OFF));
        end
        SZ_H: begin
          lane_data[8*i +: 8] = wdata[8*(i % 2) +: 8];
          be[i] = store_ok && (off[1] == !UPPER);
        end
        default: begin
          lane_data[8*i +: 8] = wdata[8*i +: 8];
          be[i] = store_ok;
        end
      endcase
    end
  end
endmodule

// File: rtl/lsa_load_ext.sv
module lsa_load_ext
  import lsa_pkg::*;
(
  input  acc_e              acc,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] rword,
  output logic [DATA_W-1:0] result
);
  logic [7:0]  sel_b;
  logic [15:0] sel_h;

  always_comb begin
    case (off)
      2'd0:    sel_b = rword[31:24];
      2'd1:    sel_b = rword[23:16];
      2'd2:    sel_b = rword[15:8];
      default: sel_b = rword[7:0];
    endcase
    sel_h = off[1] ? rword[15:0] : rword[31:16];
  end

  always_comb begin
    case (acc)
      ACC_LB:  result = {{24{sel_b[7]}}, sel_b};
      ACC_LBU: result = {24'd0, sel_b};
      ACC_LH:  result = {{16{sel_h[15]}}, sel_h};
      ACC_LHU: result = {16'd0, sel_h};
      default: result = rword;
    endcase
  end
endmodule

// File: rtl/lsa_top.sv
module lsa_top
  import lsa_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_acc,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_misalign,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_we,
  output logic [ADDR_W-3:0] mem_waddr,
  output logic [3:0]        mem_be,
  output logic [31:0]       mem_wdata,
  input  logic              mem_rvalid,
  output logic              mem_rready,
  input  logic [31:0]       mem_rdata,
  output logic              ld_valid,
  input  logic              ld_ready,
  output logic [31:0]       ld_data
);
  localparam int WADDR_W = ADDR_W - OFF_W;

  acc_e             acc_in;
  logic [OFF_W-1:0] off_in;
  logic             mis;
  logic             pend;
  acc_e             cap_acc;
  logic [OFF_W-1:0] cap_off;
  logic             accept;
  logic             load_issue;

  assign acc_in = acc_e'(req_acc);
  assign off_in = req_addr[OFF_W-1:0];

  lsa_align_chk u_align (
    .acc(acc_in), .off(off_in), .misalign(mis)
  );

  lsa_store_fmt u_store (
    .acc(acc_in), .off(off_in), .misalign(mis), .wdata(req_wdata),
    .be(mem_be), .lane_data(mem_wdata)
  );

  lsa_load_ext u_load (
    .acc(cap_acc), .off(cap_off), .rword(mem_rdata), .result(ld_data)
  );

  assign req_misalign  = req_valid && mis;
  assign mem_req_valid = req_valid && !pend && !mis;
  assign mem_we        = is_store(acc_in);
  assign mem_waddr     = req_addr[ADDR_W-1 -: WADDR_W];
  assign req_ready     = !pend && (mis || mem_req_ready);
  assign accept        = req_valid && req_ready;
  assign load_issue    = accept && !mis && !is_store(acc_in);
  assign ld_valid      = pend && mem_rvalid;
  assign mem_rready    = pend && ld_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      cap_acc <= ACC_LW;
      cap_off <= '0;
    end else begin
      if (load_issue) begin
        pend    <= 1'b1;
        cap_acc <= acc_in;
        cap_off <= off_in;
      end else if (ld_valid && ld_ready) begin
        pend    <= 1'b0;
      end
    end
  end

  a_r5_mis_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    req_misalign |-> (!mem_req_valid && mem_be == 4'b0000));
  a_r2_byte_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && req_acc == ACC_SB) |-> $onehot(mem_be));
  a_r3_half_two: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && req_acc == ACC_SH) |-> ($countones(mem_be) == 2));
  a_r1_load_no_be: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_we) |-> (mem_be == 4'b0000));
  a_r11_block_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && mem_req_valid && !mem_we) |=> !req_ready);
  a_r12_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !ld_ready) |=> !req_ready);
endmodule

// File: tb/lsa_top_tb.sv
module lsa_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_misalign;
  logic [2:0]  req_acc = 3'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        mem_req_valid, mem_req_ready = 1'b1, mem_we;
  logic [29:0] mem_waddr;
  logic [3:0]  mem_be;
  logic [31:0] mem_wdata;
  logic        mem_rvalid = 1'b0, mem_rready;
  logic [31:0] mem_rdata = '0;
  logic        ld_valid, ld_ready = 1'b0;
  logic [31:0] ld_data;

  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsa_top #(.ADDR_W(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_acc(req_acc), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_misalign(req_misalign), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
    .mem_rready(mem_rready), .mem_rdata(mem_rdata), .ld_valid(ld_valid),
    .ld_ready(ld_ready), .ld_data(ld_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_mis(input logic [2:0] a, input logic [1:0] o);
    if (a == 0 || a == 5) return o != 0;
    if (a == 1 || a == 2 || a == 6) return o[0];
    return 1'b0;
  endfunction

  function automatic logic [3:0] exp_be(input logic [2:0] a, input logic [1:0] o);
    if (exp_mis(a, o)) return 4'b0000;
    case (a)
      3'd5: return 4'b1111;
      3'd6: return o[1] ? 4'b0011 : 4'b1100;
      3'd7: return 4'b1000 >> o;
      default: return 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] exp_wd(input logic [2:0] a, input logic [31:0] w);
    case (a)
      3'd6: return {w[15:0], w[15:0]};
      3'd7: return {4{w[7:0]}};
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] exp_ld(input logic [2:0] a, input logic [1:0] o, input logic [31:0] r);
    logic [7:0]  b;
    logic [15:0] h;
    b = r[31 - 8*o -: 8];
    h = o[1] ? r[15:0] : r[31:16];
    case (a)
      3'd1: return {{16{h[15]}}, h};
      3'd2: return {16'd0, h};
      3'd3: return {{24{b[7]}}, b};
      3'd4: return {24'd0, b};
      default: return r;
    endcase
  endfunction

  function automatic string ld_req(input logic [2:0] a);
    case (a)
      3'd1: return "R8";
      3'd2: return "R9";
      3'd3: return "R6";
      3'd4: return "R7";
      default: return "R10";
    endcase
  endfunction

  function automatic string st_req(input logic [2:0] a);
    case (a)
      3'd6: return "R3";
      3'd7: return "R2";
      default: return "R4";
    endcase
  endfunction

  task automatic txn(input logic [2:0] a, input logic [31:0] addr,
                     input logic [31:0] w, input logic [31:0] r);
    logic m;
    m = exp_mis(a, addr[1:0]);
    @(negedge clk);
    req_valid = 1'b1; req_acc = a; req_addr = addr; req_wdata = w;
    mem_req_ready = ($urandom % 4) != 0;
    #1;
    chk("R5 misalign flag", 32'(req_misalign), 32'(m));
    chk("R5 enables", 32'(mem_be), 32'(exp_be(a, addr[1:0])));
    if (m) begin
      chk("R5 no mem request", 32'(mem_req_valid), 32'd0);
      chk("R5 consumed", 32'(req_ready), 32'd1);
    end else begin
      chk("R1 mem valid", 32'(mem_req_valid), 32'd1);
      chk("R1 word addr", 32'(mem_waddr), 32'(addr >> 2));
      chk("R1 write flag", 32'(mem_we), 32'(a >= 3'd5));
      if (a >= 3'd5) chk(st_req(a), mem_wdata, exp_wd(a, w));
      if (!mem_req_ready) begin
        chk("R1 wait ready", 32'(req_ready), 32'd0);
        @(negedge clk);
        mem_req_ready = 1'b1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_acc = 3'($urandom); req_addr = $urandom; mem_req_ready = 1'b1;
    #1;
    if (!m && a < 3'd5) begin
      chk("R11 blocked while pending", 32'(req_ready), 32'd0);
      chk("R12 no result before data", 32'(ld_valid), 32'd0);
      mem_rvalid = 1'b1; mem_rdata = r;
      ld_ready = ($urandom % 3) != 0;
      forever begin
        #1;
        chk("R12 valid follows", 32'(ld_valid), 32'd1);
        chk("R12 rready follows", 32'(mem_rready), 32'(ld_ready));
        chk(ld_req(a), ld_data, exp_ld(a, addr[1:0], r));
        if (ld_ready) break;
        @(negedge clk);
        req_addr = $urandom; req_acc = 3'($urandom);
        ld_ready = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      mem_rvalid = 1'b0; ld_ready = 1'b0;
      #1;
      chk("R11 ready after take", 32'(req_ready), 32'd1);
    end else begin
      chk("R11 no pending after store/misalign", 32'(req_ready), 32'd1);
    end
  endtask

  initial begin
    void'($urandom(32'h1234_5678));
    fork
      begin
        #(CLK_PERIOD * 3);
        #1;
        chk("R13 ld_valid reset", 32'(ld_valid), 32'd0);
        chk("R13 req_ready reset", 32'(req_ready), 32'd1);
        @(negedge clk); rst_n = 1'b1;
        for (int a = 0; a < 8; a++)
          for (int o = 0; o < 4; o++) begin
            txn(3'(a), 32'h0000_1000 + 32'(o), 32'h8A7B_C6D5, 32'h8090_A0F1);
            txn(3'(a), 32'h7FFF_FFF0 + 32'(o), 32'h1234_5678, 32'h7F80_01FF);
          end
        for (int k = 0; k < 400; k++)
          txn(3'($urandom), $urandom, $urandom, $urandom);
      end
      begin
        repeat (MAX_CYCLES) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule